// File: doc/BRIEF.md
# Radix-4 Most-Significant-Digit-First Signed-Digit Adder

This block adds two fixed-point fractions. The operands arrive serially, one digit pair per step, most significant digit first. Each digit is a radix-4 signed digit in the range -3..3. The sum comes out as a stream in the same redundant form, two steps behind the input. Each position sum is split into a transfer toward the more significant position and an interim digit. A transfer therefore moves by only one position, and no carry chain crosses the word. After the last operand digit the block feeds zeros to itself for two more steps. This flushes the final sum digits.

A start pulse opens an addition and clears all earlier state. The caller then presents the operand digits with a valid strobe. Gaps in that strobe stall the block. The sum has one digit more than each operand: an integer-position digit comes first, followed by one digit per fractional position. A done flag marks the end of the stream.

Top module: `rdx4_ol_adder`

## Requirements
- R1: After reset, out_valid, done and out_digit are all 0. No step is taken until a start pulse arrives.
- R2: Every digit, at the inputs and at the output, is a 3-bit two's-complement value. Only -3..3 are legal, so 3'b100 is never produced.
- R3: Operands are x = sum x_i·4^-i and y = sum y_i·4^-i for i = 1..8, sent from i = 1 upward. The output digits z_0..z_8 come in that order. Their value sum z_j·4^-j equals x + y exactly.
- R4: Exactly 9 output digits are produced. Output digit z_j is valid in the cycle after the step that consumes input digit j+2. Steps 9 and 10 are the two flush steps.
- R5: While fewer than 8 operand digits have been taken, a cycle with in_valid low is not a step. Such a cycle produces no output, and the operand digits on it are ignored.
- R6: Once 8 operand digits have been taken, the block performs two flush steps on consecutive cycles with zero operand digits. in_valid, a_digit and b_digit have no effect during the flush.
- R7: done rises in the same cycle as the last output digit. It stays high until the next start, and out_valid stays low while done is held.
- R8: A start pulse clears everything, even in the middle of an addition. In the following cycle out_valid and done are low, and the next addition is exact.
- R9: When no addition is in progress (before the first start, or after done), in_valid and the operand digits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that clears state and begins an addition |
| in_valid | input | 1 | Operand digit pair present |
| a_digit | input | 3 | First operand digit, two's complement, -3..3 |
| b_digit | input | 3 | Second operand digit, two's complement, -3..3 |
| out_valid | output | 1 | Sum digit present |
| out_digit | output | 3 | Sum digit, two's complement, -3..3 |
| done | output | 1 | All sum digits produced; held until next start |

## Verification
The assertions assume three things about the inputs:
- start is a single-cycle pulse.
- Operand digits presented with in_valid are legal, so they never take the code 3'b100.
- rst_n is deasserted before the first start.

Only under these assumptions does the output-digit range property follow from the transfer split. The stimulus draws every operand digit from -3..3, both in the vector table and in the random runs. It pulses start for exactly one cycle. During gaps and the flush it drives arbitrary but legal digit codes, so the ignore checks do not rely on illegal inputs.

// File: rtl/rdx4_ol_adder.sv
module rdx4_ol_adder #(
  parameter int DIGITS = 8,
  parameter int DW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [DW-1:0] a_digit,
  input  logic [DW-1:0] b_digit,
  output logic          out_valid,
  output logic [DW-1:0] out_digit,
  output logic          done
);
  localparam int STEPS = DIGITS + 2;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int SW    = DW + 1;

  logic                 active;
  logic [CW-1:0]        cnt;
  logic signed [DW-1:0] w_q, z_q;
  logic signed [SW-1:0] a_s, b_s, pos, tr, wi, z_next;
  logic                 feed, step;

  assign feed = cnt < CW'(DIGITS);
  assign step = active && (feed ? in_valid : 1'b1);

  assign a_s = feed ? SW'($signed(a_digit)) : '0;
  assign b_s = feed ? SW'($signed(b_digit)) : '0;
  assign pos = a_s + b_s;

  always_comb begin
    if (pos >= SW'(2))       tr = SW'(1);
    else if (pos <= -SW'(2)) tr = -SW'(1);
    else                     tr = '0;
  end

  assign wi     = pos - (tr <<< 2);
  assign z_next = SW'(w_q) + tr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      w_q       <= '0;
      z_q       <= '0;
      out_valid <= 1'b0;
      out_digit <= '0;
      done      <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      cnt       <= '0;
      w_q       <= '0;
      z_q       <= '0;
      out_valid <= 1'b0;
      out_digit <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (step) begin
        cnt <= cnt + 1'b1;
        w_q <= wi[DW-1:0];
        z_q <= z_next[DW-1:0];
        if (cnt != '0) begin
          out_valid <= 1'b1;
          out_digit <= z_q;
        end
        if (cnt == CW'(STEPS - 1)) begin
          done   <= 1'b1;
          active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rdx4_ol_adder_chk.sv
module rdx4_ol_adder_chk #(
  parameter int DW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_valid,
  input logic [DW-1:0] out_digit,
  input logic          done
);
  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_digit != {1'b1, {(DW-1){1'b0}}});

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);

  // R7
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> out_valid);

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid && !done);
endmodule

bind rdx4_ol_adder rdx4_ol_adder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .out_valid(out_valid), .out_digit(out_digit), .done(done)
);

// File: tb/rdx4_ol_adder_bench.sv
module rdx4_ol_adder_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [2:0] a_digit = '0, b_digit = '0, out_digit;
  logic out_valid, done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rdx4_ol_adder u_rdx4_ol_adder (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .a_digit(a_digit), .b_digit(b_digit),
    .out_valid(out_valid), .out_digit(out_digit), .done(done)
  );

  // {x digits (octal, MSD first), y digits, gap mask, expected sum in units of 4^-8}
  localparam logic [87:0] VEC [10] = '{
    {24'o00000000, 24'o00000000, 8'h00,  32'sd0},
    {24'o33333333, 24'o33333333, 8'h00,  32'sd131070},
    {24'o55555555, 24'o55555555, 8'h05, -32'sd131070},
    {24'o33333333, 24'o55555555, 8'h80,  32'sd0},
    {24'o10000000, 24'o10000000, 8'hFF,  32'sd32768},
    {24'o00000001, 24'o00000007, 8'h00,  32'sd0},
    {24'o20000000, 24'o30000000, 8'h12,  32'sd81920},
    {24'o00000003, 24'o00000003, 8'h00,  32'sd6},
    {24'o77777777, 24'o00000001, 8'h40, -32'sd21844},
    {24'o12312312, 24'o65656565, 8'h00, -32'sd19973}
  };

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int value(input logic [23:0] v);
    int acc = 0;
    for (int i = 0; i < 8; i++) acc = acc * 4 + int'($signed(v[23-3*i -: 3]));
    return acc;
  endfunction

  task automatic run_add(input logic [23:0] xd, input logic [23:0] yd, input logic [7:0] gaps,
                         input int exp, input string tag);
    int k = 0, steps = 0, nout = 0, zv = 0, cyc = 0, d;
    bit tok = 1, rng = 1, acc;
    logic [7:0] used = '0;
    @(negedge clk); start = 1'b1; in_valid = 1'b0;
    @(negedge clk); start = 1'b0;
    check(!out_valid && !done, "R8", {tag, " cleared after start"}, int'(out_valid) + int'(done), 0);
    while (!done && cyc < 40) begin
      acc = 0;
      if (k < 8) begin
        if (gaps[k] && !used[k]) begin
          used[k] = 1'b1; in_valid = 1'b0; a_digit = 3'b011; b_digit = 3'b101;
        end else begin
          in_valid = 1'b1; a_digit = xd[23-3*k -: 3]; b_digit = yd[23-3*k -: 3]; acc = 1;
        end
      end else begin
        in_valid = 1'b1; a_digit = 3'b011; b_digit = 3'b011;
      end
      @(negedge clk); cyc++;
      if (acc) begin k++; steps++; end
      else if (k >= 8) steps++;
      if (out_valid) begin
        d = int'($signed(out_digit));
        if (d < -3 || d > 3) rng = 0;
        if (steps != nout + 2) tok = 0;
        zv = zv * 4 + d;
        nout++;
      end
    end
    in_valid = 1'b0;
    check(zv == exp, "R3,R6", {tag, " sum value"}, zv, exp);
    check(nout == 9, "R4", {tag, " output digit count"}, nout, 9);
    check(tok, "R4,R5", {tag, " output digit timing"}, int'(tok), 1);
    check(rng, "R2", {tag, " output digit range"}, int'(rng), 1);
    check(done && steps == 10, "R7", {tag, " done after ten steps"}, steps, 10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] rx, ry;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!out_valid && !done && out_digit == 3'b000, "R1", "reset state",
          int'(out_valid) + int'(done) + int'(out_digit), 0);
    rst_n = 1'b1;
    // R9 inputs ignored before any start
    in_valid = 1'b1; a_digit = 3'b011; b_digit = 3'b011;
    repeat (6) begin
      @(negedge clk);
      check(!out_valid && !done, "R9", "idle before start", int'(out_valid) + int'(done), 0);
    end
    in_valid = 1'b0;

    for (int i = 0; i < 10; i++)
      run_add(VEC[i][87:64], VEC[i][63:40], VEC[i][39:32], $signed(VEC[i][31:0]), $sformatf("vec%0d", i));

    // R7 and R9: after done, inputs ignored and done held
    in_valid = 1'b1; a_digit = 3'b101; b_digit = 3'b101;
    repeat (5) begin
      @(negedge clk);
      check(!out_valid && done, "R7,R9", "held after done", int'(out_valid), 0);
    end
    in_valid = 1'b0;

    // R8 restart in the middle of an addition
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; in_valid = 1'b1; a_digit = 3'b011; b_digit = 3'b011;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    run_add(VEC[9][87:64], VEC[9][63:40], 8'h00, $signed(VEC[9][31:0]), "restart");

    for (int n = 0; n < 30; n++) begin
      for (int i = 0; i < 8; i++) begin
        rx[23-3*i -: 3] = 3'($signed($urandom_range(0, 6)) - 3);
        ry[23-3*i -: 3] = 3'($signed($urandom_range(0, 6)) - 3);
      end
      run_add(rx, ry, 8'($urandom), value(rx) + value(ry), $sformatf("rand%0d", n));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule